// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one asynchronous digital input. The raw level first crosses into the system clock domain through a two-flop synchronizer. While the filter is enabled, the synchronized level is sampled only on a periodic tick strobe. The output takes a new level only after that new level has been seen on a set number of consecutive ticks. Rising and falling edges follow the same rule. Any sample that still shows the current output level restarts the qualification.

Four settings pair a tick period with a required run of samples. The short setting ticks every system cycle and needs 9 samples. The medium setting ticks every system cycle and needs 512 samples. The long setting ticks once per `SLOW_DIV` cycles and needs 256 samples. The custom setting takes its tick period and its sample count from input ports. When the filter is disabled, the output follows the synchronized input with one register of delay.

Because sampling happens only on ticks, the output edge can lag the input edge by up to one extra tick period.

Top module: `pin_deglitch`

## Requirements
- R1: While reset is asserted and after it is released, `filtOut` is 0.
- R2: With `filterEn` low, `filtOut` copies `rawIn` three clock edges later: two synchronizer stages plus the output register.
- R3: `presetSel` 0 (short) ticks every cycle and needs 9 consecutive samples. A high level driven on `rawIn` before edge 1 shows at `filtOut` after edge 11, and not after edge 10.
- R4: A tick that samples the current output level resets the run count. Two high bursts of 8 cycles, separated by one low cycle, never raise the output under `presetSel` 0.
- R5: Falling transitions are qualified like rising ones. Under `presetSel` 0, a low level driven before edge 1 clears `filtOut` after edge 11 and not before.
- R6: `presetSel` 1 (medium) ticks every cycle and needs 512 samples. A 512-cycle pulse passes and a 511-cycle pulse is rejected.
- R7: `presetSel` 2 (long) ticks once every `SLOW_DIV` cycles (default 800) and needs 256 samples. Two ticks are never adjacent while the period exceeds 1.
- R8: `presetSel` 3 (custom) ticks every `customDiv` cycles and needs `customCount` samples. A value of 0 in either field acts as 1.
- R9: While enabled, any change of `presetSel`, `customDiv` or `customCount` clears the run count. That cycle takes no sample, and the output level does not change.
- R10: Raising `filterEn` starts filtering from the level already present on `filtOut`, so the output does not change when the filter is enabled.
- R11: While enabled, `filtOut` changes only in the cycle after a tick that is not overridden by a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rawIn | input | 1 | Asynchronous raw input level |
| filterEn | input | 1 | 1 enables filtering, 0 selects bypass |
| presetSel | input | 2 | 0 short, 1 medium, 2 long, 3 custom |
| customDiv | input | DIV_W | Tick period in cycles for custom mode |
| customCount | input | CNT_W | Required consecutive samples for custom mode |
| filtOut | output | 1 | Filtered level |

## Verification
A settings change can land in the same cycle as a tick that would have advanced the run count. In that case the clear wins and the sample is dropped. The bench provokes this by altering `customCount` after five qualifying samples under the short setting, so the next edge carries both a tick and a clear. It then checks that the output rises exactly nine samples after the clear rather than four samples later, and that the output level held steady through the clear.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  typedef struct packed {
    logic tick;    // sample strobe
    logic clear;   // restart qualification
    logic bypass;  // filter disabled
  } strobe_t;

  typedef enum logic [1:0] {
    PRE_SHORT  = 2'd0,
    PRE_MED    = 2'd1,
    PRE_LONG   = 2'd2,
    PRE_CUSTOM = 2'd3
  } preset_e;

endpackage

// File: rtl/deglitch_ctrl.sv
module deglitch_ctrl
  import deglitch_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 10,
  parameter int FAST_N   = 9,
  parameter int MED_N    = 512,
  parameter int SLOW_N   = 256,
  parameter int SLOW_DIV = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filterEn,
  input  logic [1:0]       presetSel,
  input  logic [DIV_W-1:0] customDiv,
  input  logic [CNT_W-1:0] customCount,
  output strobe_t          str,
  output logic [CNT_W-1:0] runLimit
);

  localparam logic [DIV_W-1:0] OneDiv  = DIV_W'(1);
  localparam logic [DIV_W-1:0] SlowDiv = DIV_W'(SLOW_DIV);
  localparam logic [CNT_W-1:0] OneCnt  = CNT_W'(1);

  logic             enActive;
  logic [1:0]       selPrev;
  logic [DIV_W-1:0] divPrev;
  logic [CNT_W-1:0] cntPrev;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] reloadVal;
  logic             cfgChanged;
  logic             clearNow;

  always_comb begin
    unique case (preset_e'(presetSel))
      PRE_SHORT: begin reloadVal = OneDiv;  runLimit = CNT_W'(FAST_N); end
      PRE_MED:   begin reloadVal = OneDiv;  runLimit = CNT_W'(MED_N);  end
      PRE_LONG:  begin reloadVal = SlowDiv; runLimit = CNT_W'(SLOW_N); end
      default: begin
        reloadVal = (customDiv == '0) ? OneDiv : customDiv;
        runLimit  = (customCount == '0) ? OneCnt : customCount;
      end
    endcase
  end

  assign cfgChanged = (presetSel != selPrev) || (customDiv != divPrev) ||
                      (customCount != cntPrev);
  assign clearNow   = filterEn && (cfgChanged || !enActive);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enActive <= 1'b0;
      selPrev  <= '0;
      divPrev  <= '0;
      cntPrev  <= '0;
      divCnt   <= OneDiv;
    end else begin
      enActive <= filterEn;
      selPrev  <= presetSel;
      divPrev  <= customDiv;
      cntPrev  <= customCount;
      if (!filterEn || clearNow || divCnt <= OneDiv) divCnt <= reloadVal;
      else                                           divCnt <= divCnt - OneDiv;
    end
  end

  assign str.tick   = filterEn && !clearNow && (divCnt <= OneDiv);
  assign str.clear  = clearNow;
  assign str.bypass = !filterEn;

  // R7: with a period above one cycle, ticks never fall on adjacent cycles
  a_r7_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (str.tick && reloadVal > OneDiv) |=> !str.tick);

endmodule

// File: rtl/deglitch_path.sv
module deglitch_path
  import deglitch_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rawIn,
  input  strobe_t          str,
  input  logic [CNT_W-1:0] runLimit,
  output logic             filtOut
);

  logic             syncA;
  logic             syncLvl;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;

  assign runNext = runCnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA   <= 1'b0;
      syncLvl <= 1'b0;
      filtOut <= 1'b0;
      runCnt  <= '0;
    end else begin
      syncA   <= rawIn;
      syncLvl <= syncA;
      if (str.bypass) begin
        filtOut <= syncLvl;
        runCnt  <= '0;
      end else if (str.clear) begin
        runCnt <= '0;
      end else if (str.tick) begin
        if (syncLvl == filtOut) begin
          runCnt <= '0;
        end else if (runNext >= runLimit) begin
          filtOut <= syncLvl;
          runCnt  <= '0;
        end else begin
          runCnt <= runNext;
        end
      end
    end
  end

  // R2: bypass copies the synchronized level
  a_r2_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    str.bypass |=> (filtOut == $past(syncLvl)));

  // R4: a sample at the present output level restarts the run
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (str.tick && !str.clear && !str.bypass && syncLvl == filtOut) |=> (runCnt == '0));

  // R9: a clear never moves the output
  a_r9_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (str.clear && !str.bypass) |=> $stable(filtOut));

  // R11: while filtering, output moves only after a live tick
  a_r11_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(filtOut) && !$past(str.bypass)) |-> $past(str.tick && !str.clear));

endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
  import deglitch_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 10,
  parameter int FAST_N   = 9,
  parameter int MED_N    = 512,
  parameter int SLOW_N   = 256,
  parameter int SLOW_DIV = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rawIn,
  input  logic             filterEn,
  input  logic [1:0]       presetSel,
  input  logic [DIV_W-1:0] customDiv,
  input  logic [CNT_W-1:0] customCount,
  output logic             filtOut
);

  strobe_t          str;
  logic [CNT_W-1:0] runLimit;

  deglitch_ctrl #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .FAST_N(FAST_N),
    .MED_N(MED_N), .SLOW_N(SLOW_N), .SLOW_DIV(SLOW_DIV)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .filterEn(filterEn), .presetSel(presetSel),
    .customDiv(customDiv), .customCount(customCount),
    .str(str), .runLimit(runLimit)
  );

  deglitch_path #(.CNT_W(CNT_W)) path_i (
    .clk(clk), .rst_n(rst_n), .rawIn(rawIn), .str(str),
    .runLimit(runLimit), .filtOut(filtOut)
  );

  // R1: output is low in the cycle after reset
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !filtOut);

endmodule

// File: tb/pin_deglitch_tb_top.sv
module pin_deglitch_tb_top;

  localparam int ClkPeriod = 10;
  localparam int LongDiv   = 8;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] len;
    logic        pass;
  } vec_t;

  // short, medium, long (LongDiv), custom (div 4, count 5)
  localparam vec_t Vecs [8] = '{
    '{2'd0, 16'd9,    1'b1}, '{2'd0, 16'd8,    1'b0},
    '{2'd1, 16'd512,  1'b1}, '{2'd1, 16'd511,  1'b0},
    '{2'd2, 16'd2100, 1'b1}, '{2'd2, 16'd1900, 1'b0},
    '{2'd3, 16'd24,   1'b1}, '{2'd3, 16'd12,   1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rawIn = 1'b0;
  logic        filterEn = 1'b0;
  logic [1:0]  presetSel = 2'd0;
  logic [15:0] customDiv = 16'd4;
  logic [9:0]  customCount = 10'd5;
  logic        filtOut;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  pin_deglitch #(.SLOW_DIV(LongDiv)) dut_i (
    .clk(clk), .rst_n(rst_n), .rawIn(rawIn), .filterEn(filterEn),
    .presetSel(presetSel), .customDiv(customDiv), .customCount(customCount),
    .filtOut(filtOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic sawHigh;
    @(negedge clk);
    step(3);
    chk("R1 in reset", filtOut, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset", filtOut, 1'b0);

    // R2 bypass latency
    rawIn = 1'b1;
    step(2);
    chk("R2 not yet", filtOut, 1'b0);
    step(1);
    chk("R2 follows", filtOut, 1'b1);

    // R10 enable while high keeps level
    presetSel = 2'd0;
    filterEn = 1'b1;
    step(1);
    chk("R10 enable no change", filtOut, 1'b1);
    step(5);
    chk("R10 still high", filtOut, 1'b1);

    // R5 falling qualification
    rawIn = 1'b0;
    step(10);
    chk("R5 not yet", filtOut, 1'b1);
    step(1);
    chk("R5 falls", filtOut, 1'b0);
    step(4);

    // R3 rising qualification
    rawIn = 1'b1;
    step(10);
    chk("R3 not yet", filtOut, 1'b0);
    step(1);
    chk("R3 rises", filtOut, 1'b1);
    rawIn = 1'b0;
    step(20);

    // R4 restart on an old-level sample
    rawIn = 1'b1; step(8);
    rawIn = 1'b0; step(1);
    rawIn = 1'b1; step(8);
    rawIn = 1'b0;
    sawHigh = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      sawHigh |= filtOut;
    end
    chk("R4 restart rejects", sawHigh, 1'b0);

    // R9 clear on settings change meets a tick in the same cycle
    rawIn = 1'b1;
    step(7);
    customCount = 10'd6;
    step(9);
    chk("R9 cleared run", filtOut, 1'b0);
    step(1);
    chk("R9 rises after restart", filtOut, 1'b1);
    rawIn = 1'b0;
    step(20);
    customCount = 10'd5;

    // R8 zero divider acts as one, count 3
    customDiv = 16'd0;
    customCount = 10'd3;
    presetSel = 2'd3;
    step(4);
    rawIn = 1'b1;
    step(4);
    chk("R8 not yet", filtOut, 1'b0);
    step(1);
    chk("R8 custom rises", filtOut, 1'b1);
    rawIn = 1'b0;
    step(20);
    customDiv = 16'd4;
    customCount = 10'd5;

    // table: R3/R6/R7/R8 pulse pass or reject
    foreach (Vecs[k]) begin
      presetSel = Vecs[k].sel;
      step(6);
      sawHigh = 1'b0;
      rawIn = 1'b1;
      for (int i = 0; i < int'(Vecs[k].len); i++) begin
        step(1);
        sawHigh |= filtOut;
      end
      rawIn = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        step(1);
        sawHigh |= filtOut;
      end
      case (Vecs[k].sel)
        2'd0:    chk("R3 short pulse", sawHigh, Vecs[k].pass);
        2'd1:    chk("R6 medium pulse", sawHigh, Vecs[k].pass);
        2'd2:    chk("R7 long pulse", sawHigh, Vecs[k].pass);
        default: chk("R8 custom pulse", sawHigh, Vecs[k].pass);
      endcase
      chk("R5 settles low", filtOut, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule